// File: doc/BRIEF.md
# Prime-Module Vector Memory Address Mapper

This block sits in front of a vector memory split into 2^K+1 independent modules. Element addresses from two read ports and one write port arrive each cycle. Each address passes through a reversible bit scramble. The scrambled value picks a module by a remainder modulo 2^K+1 and a word inside that module by dropping its K low bits. The module count is odd, so power-of-two strides spread across all modules. With plain low-order interleaving, such strides would pile onto a single module.

After a module takes a request it stays occupied for a fixed number of cycles. A request that finds its module occupied, or that loses arbitration, waits in a small buffer owned by its port. That buffer retries every cycle, and the port keeps sending new requests while the buffer has room. The block drives one strobe per module, together with the word address and the number of the port served. Each port also gets a stall flag. The storage arrays are outside the block.

Top module: `vector_addr_mapper`

## Requirements
- R1: The scrambled address is h = a XOR (a >> (ADDR_W/2)). The upper half of the address passes unchanged and the lower half is XORed with the upper half, so the mapping is one-to-one.
- R2: A granted request raises mod_strobe[h mod (2^K+1)] and no other strobe bit. With the defaults, K=3 and there are 9 modules.
- R3: The word presented with a grant is h >> K, placed on mod_word bits [m*WORD_W +: WORD_W] for module m.
- R4: Requests from rd0 (port code 0), rd1 (code 1) and wr (code 2) to different free modules are all granted in the same cycle. Each grant carries its port code on mod_src bits [m*2 +: 2].
- R5: A module that grants in cycle c refuses all requests in cycles c+1 through c+BUSY_CYC, and can grant again in cycle c+BUSY_CYC+1.
- R6: A new request that is not granted and finds room in its port buffer is accepted. It is retried every cycle and is granted in the first cycle its module is free and no request with higher priority targets that module.
- R7: Among requests to the same free module, buffered requests win over new ones. Within each group the order is rd0, then rd1, then wr.
- R8: Buffered requests of one port are granted in the order they were accepted.
- R9: stall for a port is high exactly when that port has a valid new request that is not granted and its buffer already holds BUF_DEPTH entries. A stalled request is not taken and is never served unless the source presents it again.
- R10: Reset empties all buffers and frees all modules. Right after reset no strobe or stall is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd0_valid | input | 1 | Read port 0 request valid |
| rd0_addr | input | ADDR_W | Read port 0 element address |
| rd1_valid | input | 1 | Read port 1 request valid |
| rd1_addr | input | ADDR_W | Read port 1 element address |
| wr_valid | input | 1 | Write port request valid |
| wr_addr | input | ADDR_W | Write port element address |
| mod_strobe | output | NMOD | Per-module request strobe |
| mod_word | output | NMOD*WORD_W | Per-module word address |
| mod_src | output | NMOD*2 | Per-module port code of the served request |
| stall | output | 3 | Per-port stall, bit 0 rd0, bit 1 rd1, bit 2 wr |

## Verification
The mapping is swept over every address of the default 12-bit space, one at a time, with the modules idle in between. This separates errors in the scramble, the remainder and the word shift from effects of arbitration. Directed collision patterns follow. Two ports hit one module to expose the busy window and the retry. A buffered request then meets a new request from a higher-priority port, which distinguishes buffer-first priority from port-first priority. A single port streams to one module until its buffer fills, to check the drain order and the exact stall cycle. Three ports aimed at distinct modules confirm that grants run in parallel, and a reset in the middle of a conflict confirms that buffered work is discarded.

// File: rtl/vmap_pkg.sv
// Shared constants and port codes for the vector address mapper.
package vmap_pkg;
    localparam int NPORT = 3;
    localparam int SRC_W = 2;

    typedef enum logic [SRC_W-1:0] {
        SRC_RD0 = 2'd0,
        SRC_RD1 = 2'd1,
        SRC_WR  = 2'd2
    } port_code_e;
endpackage

// File: rtl/vmap_hash.sv
// Scrambles an element address one-to-one and splits the result into a
// module index (remainder modulo 2^K+1) and an in-module word (drop K bits).
// Assumes ADDR_W is even and larger than K.
module vmap_hash #(
    parameter int ADDR_W = 12,
    parameter int K      = 3,
    localparam int NMOD   = (1 << K) + 1,
    localparam int MOD_W  = $clog2(NMOD),
    localparam int WORD_W = ADDR_W - K,
    localparam int HALF   = ADDR_W / 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [MOD_W-1:0]  mod_idx,
    output logic [WORD_W-1:0] word
);
    logic [ADDR_W-1:0] scrambled;

    // Fold the upper half onto the lower half, then split the result.
    always_comb begin
        scrambled = addr ^ (addr >> HALF);
        mod_idx   = MOD_W'(scrambled % ADDR_W'(NMOD));
        word      = scrambled[ADDR_W-1:K];
    end
endmodule

// File: rtl/vmap_port_fifo.sv
// Small circular buffer that holds one port's deferred requests.
// Assumes the caller never pushes while full and never pops while empty.
module vmap_port_fifo #(
    parameter int W     = 13,
    parameter int DEPTH = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;

    // Pointer wrap helper for depths that are not powers of two.
    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Advance pointers and occupancy on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_data;
                wr_ptr        <= nxt(wr_ptr);
            end
            if (pop) rd_ptr <= nxt(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // Present the oldest entry and the occupancy flags.
    always_comb begin
        head  = slots[rd_ptr];
        empty = (count == '0);
        full  = (count == CNT_W'(DEPTH));
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/vmap_mod_arbiter.sv
// Grants one module to the first matching candidate (index 0 highest) when
// the module is free, and then holds it busy for BUSY_CYC cycles.
// Assumes candidates are already filtered to those that target this module.
module vmap_mod_arbiter #(
    parameter int NCAND    = 6,
    parameter int WORD_W   = 9,
    parameter int SRC_W    = 2,
    parameter int BUSY_CYC = 2,
    localparam int BUSY_W  = $clog2(BUSY_CYC + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NCAND-1:0]              hit,
    input  logic [NCAND-1:0][WORD_W-1:0]  cand_word,
    input  logic [NCAND-1:0][SRC_W-1:0]   cand_src,
    output logic [NCAND-1:0]              grant,
    output logic                          strobe,
    output logic [WORD_W-1:0]             word,
    output logic [SRC_W-1:0]              src
);
    logic [BUSY_W-1:0] busy_cnt;

    // Fixed-priority pick of the lowest-indexed hit while the module is free.
    always_comb begin
        grant  = '0;
        strobe = 1'b0;
        word   = '0;
        src    = '0;
        for (int c = 0; c < NCAND; c++) begin
            if (hit[c] && !strobe && busy_cnt == '0) begin
                grant[c] = 1'b1;
                strobe   = 1'b1;
                word     = cand_word[c];
                src      = cand_src[c];
            end
        end
    end

    // Load the busy window on a grant and count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)               busy_cnt <= '0;
        else if (strobe)          busy_cnt <= BUSY_W'(BUSY_CYC);
        else if (busy_cnt != '0)  busy_cnt <= busy_cnt - 1'b1;
    end

    assert_busy_after_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
endmodule

// File: rtl/vector_addr_mapper.sv
// Top of the mapper: scrambles the three port addresses, buffers requests
// that lose or meet a busy module, and arbitrates each of the 2^K+1 modules.
// Candidate order: buffered rd0, rd1, wr, then new rd0, rd1, wr.
// Assumes a stalled source holds or drops its request itself.
module vector_addr_mapper #(
    parameter int ADDR_W    = 12,
    parameter int K         = 3,
    parameter int BUSY_CYC  = 2,
    parameter int BUF_DEPTH = 2,
    localparam int NMOD   = (1 << K) + 1,
    localparam int MOD_W  = $clog2(NMOD),
    localparam int WORD_W = ADDR_W - K,
    localparam int NP     = vmap_pkg::NPORT,
    localparam int SRC_W  = vmap_pkg::SRC_W,
    localparam int NC     = 2 * NP,
    localparam int ENT_W  = MOD_W + WORD_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd0_valid,
    input  logic [ADDR_W-1:0]        rd0_addr,
    input  logic                     rd1_valid,
    input  logic [ADDR_W-1:0]        rd1_addr,
    input  logic                     wr_valid,
    input  logic [ADDR_W-1:0]        wr_addr,
    output logic [NMOD-1:0]          mod_strobe,
    output logic [NMOD*WORD_W-1:0]   mod_word,
    output logic [NMOD*SRC_W-1:0]    mod_src,
    output logic [NP-1:0]            stall
);
    logic [NP-1:0]              req_v;
    logic [NP-1:0][ADDR_W-1:0]  req_a;
    logic [MOD_W-1:0]           new_mod  [NP];
    logic [WORD_W-1:0]          new_word [NP];
    logic [ENT_W-1:0]           buf_head [NP];
    logic [NP-1:0]              buf_empty, buf_full, buf_push, buf_pop;

    logic [NC-1:0]              cand_v;
    logic [MOD_W-1:0]           cand_mod [NC];
    logic [NC-1:0][WORD_W-1:0]  cand_word;
    logic [NC-1:0][SRC_W-1:0]   cand_src;
    logic [NC-1:0]              hit  [NMOD];
    logic [NC-1:0]              gnt  [NMOD];
    logic [NMOD-1:0]            gnt_col [NC];
    logic [NC-1:0]              cand_taken;

    // Gather the three ports into indexable arrays.
    always_comb begin
        req_v = {wr_valid, rd1_valid, rd0_valid};
        req_a = {wr_addr, rd1_addr, rd0_addr};
    end

    for (genvar p = 0; p < NP; p++) begin : g_port
        vmap_hash #(.ADDR_W(ADDR_W), .K(K)) u_hash (
            .addr    (req_a[p]),
            .mod_idx (new_mod[p]),
            .word    (new_word[p])
        );

        vmap_port_fifo #(.W(ENT_W), .DEPTH(BUF_DEPTH)) u_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (buf_push[p]),
            .push_data ({new_mod[p], new_word[p]}),
            .pop       (buf_pop[p]),
            .head      (buf_head[p]),
            .empty     (buf_empty[p]),
            .full      (buf_full[p])
        );

        // Pop on a buffered grant; defer or stall a new request that lost.
        always_comb begin
            buf_pop[p]  = cand_taken[p];
            buf_push[p] = req_v[p] && !cand_taken[NP+p] && !buf_full[p];
            stall[p]    = req_v[p] && !cand_taken[NP+p] && buf_full[p];
        end
    end

    // Build the candidate list in priority order.
    always_comb begin
        for (int p = 0; p < NP; p++) begin
            cand_v[p]         = !buf_empty[p];
            cand_mod[p]       = buf_head[p][ENT_W-1:WORD_W];
            cand_word[p]      = buf_head[p][WORD_W-1:0];
            cand_src[p]       = SRC_W'(p);
            cand_v[NP+p]      = req_v[p];
            cand_mod[NP+p]    = new_mod[p];
            cand_word[NP+p]   = new_word[p];
            cand_src[NP+p]    = SRC_W'(p);
        end
    end

    for (genvar m = 0; m < NMOD; m++) begin : g_mod
        // Select the candidates aimed at this module.
        always_comb begin
            for (int c = 0; c < NC; c++)
                hit[m][c] = cand_v[c] && (cand_mod[c] == MOD_W'(m));
        end

        vmap_mod_arbiter #(
            .NCAND(NC), .WORD_W(WORD_W), .SRC_W(SRC_W), .BUSY_CYC(BUSY_CYC)
        ) u_arb (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit       (hit[m]),
            .cand_word (cand_word),
            .cand_src  (cand_src),
            .grant     (gnt[m]),
            .strobe    (mod_strobe[m]),
            .word      (mod_word[m*WORD_W +: WORD_W]),
            .src       (mod_src[m*SRC_W +: SRC_W])
        );
    end

    // Collect, per candidate, which modules granted it.
    always_comb begin
        for (int c = 0; c < NC; c++) begin
            for (int m = 0; m < NMOD; m++) gnt_col[c][m] = gnt[m][c];
            cand_taken[c] = |gnt_col[c];
        end
    end

    for (genvar c = 0; c < NC; c++) begin : g_chk
        assert_single_module_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gnt_col[c]));
    end
endmodule

// File: tb/vector_addr_mapper_bench.sv
`timescale 1ns/1ps
module vector_addr_mapper_bench;
    localparam int ADDR_W = 12;
    localparam int K      = 3;
    localparam int BUSY   = 2;
    localparam int DEPTH  = 2;
    localparam int NMOD   = (1 << K) + 1;
    localparam int WORD_W = ADDR_W - K;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd0_valid = 0, rd1_valid = 0, wr_valid = 0;
    logic [ADDR_W-1:0] rd0_addr = '0, rd1_addr = '0, wr_addr = '0;
    logic [NMOD-1:0] mod_strobe;
    logic [NMOD*WORD_W-1:0] mod_word;
    logic [NMOD*2-1:0] mod_src;
    logic [2:0] stall;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    vector_addr_mapper #(.ADDR_W(ADDR_W), .K(K), .BUSY_CYC(BUSY), .BUF_DEPTH(DEPTH))
    u_vector_addr_mapper (
        .clk(clk), .rst_n(rst_n),
        .rd0_valid(rd0_valid), .rd0_addr(rd0_addr),
        .rd1_valid(rd1_valid), .rd1_addr(rd1_addr),
        .wr_valid(wr_valid), .wr_addr(wr_addr),
        .mod_strobe(mod_strobe), .mod_word(mod_word), .mod_src(mod_src),
        .stall(stall)
    );

    function automatic int e_hash(input int a);
        return (a ^ (a >> (ADDR_W/2))) & ((1 << ADDR_W) - 1);
    endfunction
    function automatic int e_mod(input int a);
        return e_hash(a) % NMOD;
    endfunction
    function automatic int e_word(input int a);
        return e_hash(a) >> K;
    endfunction
    // n-th address (from 0) whose module is m.
    function automatic int addr_for(input int m, input int n);
        int seen = 0;
        for (int a = 0; a < (1 << ADDR_W); a++) begin
            if (e_mod(a) == m) begin
                if (seen == n) return a;
                seen++;
            end
        end
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive inputs at the falling edge and settle before sampling.
    task automatic drive(input bit v0, input int a0, input bit v1, input int a1,
                         input bit v2, input int a2);
        @(negedge clk);
        rd0_valid = v0; rd0_addr = ADDR_W'(a0);
        rd1_valid = v1; rd1_addr = ADDR_W'(a1);
        wr_valid  = v2; wr_addr  = ADDR_W'(a2);
        #1;
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0);
    endtask

    function automatic int w_of(input int m);
        return int'(mod_word[m*WORD_W +: WORD_W]);
    endfunction
    function automatic int s_of(input int m);
        return int'(mod_src[m*2 +: 2]);
    endfunction

    task automatic expect_grant(input int m, input int src, input int word, input string req);
        check(mod_strobe[m] && s_of(m) == src && w_of(m) == word, req,
              mod_strobe[m] ? s_of(m) * 10000 + w_of(m) : -1, src * 10000 + word);
    endtask
    task automatic expect_quiet(input int m, input string req);
        check(!mod_strobe[m], req, int'(mod_strobe[m]), 0);
    endtask

    initial begin
        #(150000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int a, b, c, m;
        idle(3);
        @(negedge clk); rst_n = 1'b1; #1;
        // R10: quiet after reset
        check(mod_strobe == '0 && stall == '0, "R10", int'(mod_strobe), 0);

        // R1 R2 R3: full address sweep on rd0, idle modules
        for (int x = 0; x < (1 << ADDR_W); x++) begin
            drive(1, x, 0, 0, 0, 0);
            check(mod_strobe[e_mod(x)] && $countones(mod_strobe) == 1
                  && w_of(e_mod(x)) == e_word(x) && s_of(e_mod(x)) == 0,
                  "R1/R2/R3 map", int'(mod_strobe), 1 << e_mod(x));
            idle(BUSY);
        end

        // R4: three ports, three distinct modules, same cycle
        a = addr_for(0, 0); b = addr_for(1, 0); c = addr_for(2, 0);
        drive(1, a, 1, b, 1, c);
        expect_grant(0, 0, e_word(a), "R4 rd0");
        expect_grant(1, 1, e_word(b), "R4 rd1");
        expect_grant(2, 2, e_word(c), "R4 wr");
        idle(BUSY + 1);

        // R5 R6 R7: conflict, busy window, buffered beats new rd0
        m = 4; a = addr_for(m, 0); b = addr_for(m, 1); c = addr_for(m, 2);
        drive(1, a, 1, b, 0, 0);
        expect_grant(m, 0, e_word(a), "R7 rd0 over rd1");
        drive(0, 0, 0, 0, 0, 0); expect_quiet(m, "R5 busy c+1");
        drive(0, 0, 0, 0, 0, 0); expect_quiet(m, "R5 busy c+2");
        drive(1, c, 0, 0, 0, 0);
        expect_grant(m, 1, e_word(b), "R6 R7 buffered first");
        idle(2);
        drive(0, 0, 0, 0, 0, 0);
        expect_grant(m, 0, e_word(c), "R6 retry of rd0");
        idle(BUSY + 1);

        // R7: new rd1 over new wr; wr retried later
        m = 6; a = addr_for(m, 0); b = addr_for(m, 1);
        drive(0, 0, 1, a, 1, b);
        expect_grant(m, 1, e_word(a), "R7 rd1 over wr");
        idle(2);
        drive(0, 0, 0, 0, 0, 0);
        expect_grant(m, 2, e_word(b), "R6 wr retry");
        idle(BUSY + 1);

        // R8 R9: stream rd0 into one module until stall
        m = 7;
        drive(1, addr_for(m, 0), 0, 0, 0, 0);
        expect_grant(m, 0, e_word(addr_for(m, 0)), "R8 first");
        drive(1, addr_for(m, 1), 0, 0, 0, 0);
        check(stall == '0, "R9 no stall one buffered", int'(stall), 0);
        drive(1, addr_for(m, 2), 0, 0, 0, 0);
        check(stall == '0, "R9 no stall with room", int'(stall), 0);
        drive(1, addr_for(m, 3), 1, addr_for(8, 0), 0, 0);
        check(stall == 3'b001, "R9 stall when full", int'(stall), 1);
        expect_grant(m, 0, e_word(addr_for(m, 1)), "R8 order second");
        idle(2);
        drive(0, 0, 0, 0, 0, 0);
        expect_grant(m, 0, e_word(addr_for(m, 2)), "R8 order third");
        idle(2);
        drive(0, 0, 0, 0, 0, 0);
        expect_quiet(m, "R9 stalled request dropped");
        idle(BUSY + 1);

        // R10: reset discards a buffered request
        m = 5; a = addr_for(m, 0); b = addr_for(m, 1);
        drive(1, a, 1, b, 0, 0);
        @(negedge clk); rst_n = 1'b0; rd0_valid = 0; rd1_valid = 0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < BUSY + 2; i++) begin
            drive(0, 0, 0, 0, 0, 0);
            check(mod_strobe == '0, "R10 buffer cleared", int'(mod_strobe), 0);
        end
        drive(1, b, 0, 0, 0, 0);
        expect_grant(m, 0, e_word(b), "R10 module free after reset");
        idle(BUSY + 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule